// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer of 512 words, 18 bits each, placed between two unrelated clock domains. A producer presents a word on `d_in` and raises `ld_en`. The word is stored on the next rising edge of `ld_clk`. A consumer watches `q_out`. The oldest stored word shows up there on its own, with no read request, and `empty_n` rises to say it is valid. Raising `un_en` for one `un_clk` edge discards that word, and the word after it takes its place.

Four status outputs report how full the buffer is. `full_n` and `empty_n` are active low. `half_full` is high from 256 words upward. `almost` is a single flag that is high near either end of the range. Its two thresholds are a low-end offset and a high-end offset. Both are loaded from the low nine bits of `d_in` on the first one or two accepted load edges after reset, while `prog_n` is held low. If they are not loaded, both default to 64. The `rst_n` input clears both domains asynchronously. `oe_n` places the data outputs in high impedance.

Top module: `dcf_fifo`

## Requirements
- R1: The buffer accepts exactly 512 words. `full_n` is low when 512 words are held and high otherwise.
- R2: A load edge while full changes nothing. The stored contents and their order stay the same, and the extra word never appears at the output.
- R3: An unload edge while `empty_n` is low has no effect. The next word written is the next word delivered.
- R4: The first word written into an empty buffer appears on `q_out` with `empty_n` high, within four `un_clk` edges of its load edge, and without any `un_en` pulse.
- R5: `half_full` is high when 256 or more words are held and low at 255 or fewer.
- R6: With low offset X and high offset Y, `almost` is high when the count is at most X or at least 512−Y. It is low from X+1 through 511−Y.
- R7: After reset, the first accepted load edge with `prog_n` low takes X from `d_in[8:0]`. A second such edge takes Y from `d_in[8:0]`. Neither edge stores a word.
- R8: If `prog_n` is high on the second accepted edge, Y copies X and that edge stores its word normally. If `prog_n` is high on the first edge, both offsets stay at 64 and the word is stored.
- R9: While `rst_n` is low and just after it is released, `full_n` is 1, `empty_n` is 0, `half_full` is 0 and `almost` is 1.
- R10: While `oe_n` is high, every bit of `q_out` is high impedance. While `oe_n` is low, `q_out` shows the head word.
- R11: Words leave in the order they were written, with their values unchanged, under any mix of load and unload traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load-side clock |
| ld_en | input | 1 | Load strobe, sampled on `ld_clk` rising edge |
| d_in | input | 18 | Write data; bits 8:0 also carry the offsets while programming |
| prog_n | input | 1 | Active-low offset programming select |
| un_clk | input | 1 | Unload-side clock |
| un_en | input | 1 | Discard the head word, sampled on `un_clk` rising edge |
| oe_n | input | 1 | Active-low output enable for `q_out` |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| q_out | output | 18 | Head word, high impedance when `oe_n` is high |
| full_n | output | 1 | Low when 512 words are held |
| empty_n | output | 1 | High when `q_out` holds a valid head word |
| half_full | output | 1 | High at 256 words or more |
| almost | output | 1 | High near either end of the occupancy range |

## Verification
`full_n`, `half_full` and `almost` are computed on the load side. After a load they settle at the next `ld_clk` edge. After an unload they settle only once the read pointer has passed through a two-stage synchronizer, which takes about three `ld_clk` edges. For this reason the bench reads flags only after ten idle `un_clk` periods, and it keeps its random traffic well below the full mark. A newly written word reaches the unload side after two synchronizer stages and one output register, so the first-word check counts `un_clk` edges and allows up to four. Once a word is at the head, a discard makes the next word valid one `un_clk` edge later, so pops are issued only when `empty_n` is seen high at a falling edge. All samples are taken on falling edges of `un_clk`, which never coincide with a rising edge of `ld_clk`.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    typedef enum logic [1:0] {
        PH_LOW_OFF  = 2'd0,
        PH_HIGH_OFF = 2'd1,
        PH_RUN      = 2'd2
    } prog_ph_e;

    localparam int DEF_DATA_W  = 18;
    localparam int DEF_ADDR_W  = 9;
    localparam int DEF_OFFSET  = 64;
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage1 = gray_in;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Gray to binary: each bit is the parity of all gray bits at or above it
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(s_q.stage2 >> i);
        end
    end
endmodule

// File: rtl/dcf_store.sv
`timescale 1ns/1ps
module dcf_store #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_ld_ctrl.sv
`timescale 1ns/1ps
module dcf_ld_ctrl
    import dcf_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 9,
    parameter int OFF_DEF = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          prog_n,
    input  logic [DW-1:0] d_in,
    input  logic [AW:0]   rd_bin,
    output logic [AW:0]   wr_bin,
    output logic [AW:0]   wr_gray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   cnt,
    output logic          full_n,
    output logic          half_full,
    output logic          almost
);
    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        prog_ph_e      ph;
        logic [AW-1:0] lo_off;
        logic [AW-1:0] hi_off;
    } ld_st_t;

    localparam ld_st_t RST_ST = '{
        ptr:    '0,
        gray:   '0,
        ph:     PH_LOW_OFF,
        lo_off: AW'(OFF_DEF),
        hi_off: AW'(OFF_DEF)
    };

    ld_st_t s_d, s_q;
    logic   is_full;
    logic   store_req;

    always_comb begin
        s_d       = s_q;
        store_req = 1'b0;
        cnt       = s_q.ptr - rd_bin;
        is_full   = (cnt == DEPTH_P);

        if (ld_en) begin
            unique case (s_q.ph)
                PH_LOW_OFF: begin
                    if (!prog_n) begin
                        s_d.lo_off = d_in[AW-1:0];
                        s_d.ph     = PH_HIGH_OFF;
                    end else begin
                        s_d.ph    = PH_RUN;
                        store_req = 1'b1;
                    end
                end
                PH_HIGH_OFF: begin
                    s_d.ph = PH_RUN;
                    if (!prog_n) begin
                        s_d.hi_off = d_in[AW-1:0];
                    end else begin
                        s_d.hi_off = s_q.lo_off;
                        store_req  = 1'b1;
                    end
                end
                default: store_req = 1'b1;
            endcase
        end

        we = store_req && !is_full;
        if (we) s_d.ptr = s_q.ptr + 1'b1;
        s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_ST;
        else        s_q <= s_d;
    end

    assign wr_bin    = s_q.ptr;
    assign wr_gray   = s_q.gray;
    assign waddr     = s_q.ptr[AW-1:0];
    assign full_n    = !is_full;
    assign half_full = (cnt >= HALF_P);
    assign almost    = (cnt <= {1'b0, s_q.lo_off}) ||
                       (cnt >= (DEPTH_P - {1'b0, s_q.hi_off}));
endmodule

// File: rtl/dcf_un_ctrl.sv
`timescale 1ns/1ps
module dcf_un_ctrl #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          un_en,
    input  logic [AW:0]   wr_bin,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_bin,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] head,
    output logic          empty_n
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          vld;
        logic [DW-1:0] data;
    } un_st_t;

    un_st_t s_d, s_q;
    logic   take;

    always_comb begin
        s_d   = s_q;
        take  = s_q.vld && un_en;
        s_d.ptr  = s_q.ptr + {{(PW-1){1'b0}}, take};
        s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
        raddr    = s_d.ptr[AW-1:0];
        s_d.vld  = (wr_bin != s_d.ptr);
        if (s_d.vld) s_d.data = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_bin  = s_q.ptr;
    assign rd_gray = s_q.gray;
    assign head    = s_q.data;
    assign empty_n = s_q.vld;
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
    parameter int DW      = dcf_pkg::DEF_DATA_W,
    parameter int AW      = dcf_pkg::DEF_ADDR_W,
    parameter int OFF_DEF = dcf_pkg::DEF_OFFSET
) (
    input  logic          ld_clk,
    input  logic          ld_en,
    input  logic [DW-1:0] d_in,
    input  logic          prog_n,
    input  logic          un_clk,
    input  logic          un_en,
    input  logic          oe_n,
    input  logic          rst_n,
    output logic [DW-1:0] q_out,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_full,
    output logic          almost
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_bin_w, wr_gray_w, rd_bin_w, rd_gray_w;
    logic [PW-1:0] rd_bin_at_ld, wr_bin_at_un;
    logic [PW-1:0] wcnt_w;
    logic          we_w;
    logic [AW-1:0] waddr_w, raddr_w;
    logic [DW-1:0] rdata_w, head_w;

    dcf_ld_ctrl #(.DW(DW), .AW(AW), .OFF_DEF(OFF_DEF)) u_ld (
        .clk(ld_clk), .rst_n(rst_n), .ld_en(ld_en), .prog_n(prog_n),
        .d_in(d_in), .rd_bin(rd_bin_at_ld), .wr_bin(wr_bin_w),
        .wr_gray(wr_gray_w), .we(we_w), .waddr(waddr_w), .cnt(wcnt_w),
        .full_n(full_n), .half_full(half_full), .almost(almost)
    );

    dcf_ptr_sync #(.W(PW)) u_rd2ld (
        .clk(ld_clk), .rst_n(rst_n), .gray_in(rd_gray_w), .bin_out(rd_bin_at_ld)
    );

    dcf_ptr_sync #(.W(PW)) u_wr2un (
        .clk(un_clk), .rst_n(rst_n), .gray_in(wr_gray_w), .bin_out(wr_bin_at_un)
    );

    dcf_store #(.DW(DW), .AW(AW)) u_mem (
        .wclk(ld_clk), .we(we_w), .waddr(waddr_w), .wdata(d_in),
        .raddr(raddr_w), .rdata(rdata_w)
    );

    dcf_un_ctrl #(.DW(DW), .AW(AW)) u_un (
        .clk(un_clk), .rst_n(rst_n), .un_en(un_en), .wr_bin(wr_bin_at_un),
        .mem_rdata(rdata_w), .raddr(raddr_w), .rd_bin(rd_bin_w),
        .rd_gray(rd_gray_w), .head(head_w), .empty_n(empty_n)
    );

    assign q_out = oe_n ? {DW{1'bz}} : head_w;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input logic          ld_clk,
    input logic          un_clk,
    input logic          rst_n,
    input logic          ld_en,
    input logic          un_en,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_full,
    input logic          almost,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rd_ptr,
    input logic [AW:0]   wcnt,
    input logic [DW-1:0] head
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    AST_CNT_LIMIT: assert property (@(posedge ld_clk) disable iff (!rst_n)
        wcnt <= DEPTH_P); // R1

    AST_FULL_BLOCKS: assert property (@(posedge ld_clk) disable iff (!rst_n)
        (!full_n && ld_en) |=> $stable(wr_ptr)); // R2

    AST_EMPTY_BLOCKS: assert property (@(posedge un_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_ptr)); // R3

    AST_HEAD_HOLD: assert property (@(posedge un_clk) disable iff (!rst_n)
        (empty_n && !un_en) |=> (empty_n && $stable(head))); // R4

    AST_FULL_FLAGS: assert property (@(posedge ld_clk) disable iff (!rst_n)
        !full_n |-> (half_full && almost)); // R5

    AST_WR_STEP: assert property (@(posedge ld_clk) disable iff (!rst_n)
        (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + 1'b1)); // R11
endmodule

bind dcf_fifo dcf_chk #(.DW(DW), .AW(AW)) u_chk (
    .ld_clk(ld_clk), .un_clk(un_clk), .rst_n(rst_n), .ld_en(ld_en),
    .un_en(un_en), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .almost(almost), .wr_ptr(wr_bin_w),
    .rd_ptr(rd_bin_w), .wcnt(wcnt_w), .head(head_w)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
    localparam int DW = 18;
    localparam int DEPTH = 512;

    logic          ld_clk = 1'b0, un_clk = 1'b0;
    logic          rst_n = 1'b0, ld_en = 1'b0, un_en = 1'b0;
    logic          prog_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] d_in = '0;
    wire  [DW-1:0] q_out;
    logic          full_n, empty_n, half_full, almost;

    dcf_fifo u_dcf_fifo (
        .ld_clk(ld_clk), .ld_en(ld_en), .d_in(d_in), .prog_n(prog_n),
        .un_clk(un_clk), .un_en(un_en), .oe_n(oe_n), .rst_n(rst_n),
        .q_out(q_out), .full_n(full_n), .empty_n(empty_n),
        .half_full(half_full), .almost(almost)
    );

    initial begin
        #1;
        forever #4 ld_clk = ~ld_clk;
    end
    always #5 un_clk = ~un_clk;

    int            n_chk = 0, n_bad = 0;
    int            lo_x = 64, hi_y = 64, phase = 0;
    bit            ended = 1'b0;
    logic [DW-1:0] model [$];
    int unsigned   seed_v;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit exp_half(input int c);
        return c >= DEPTH / 2;
    endfunction
    function automatic bit exp_alm(input int c);
        return (c <= lo_x) || (c >= DEPTH - hi_y);
    endfunction

    task automatic reset_dut();
        rst_n = 1'b0; ld_en = 1'b0; un_en = 1'b0; prog_n = 1'b1;
        repeat (3) @(negedge un_clk);
        rst_n = 1'b1;
        model.delete();
        lo_x = 64; hi_y = 64; phase = 0;
    endtask

    // One accepted load edge; the model follows R7, R8, R2
    task automatic ld_edge(input logic [DW-1:0] w, input bit prog_low);
        bit store;
        @(negedge ld_clk);
        ld_en = 1'b1; d_in = w; prog_n = !prog_low;
        @(negedge ld_clk);
        ld_en = 1'b0; prog_n = 1'b1;
        store = 1'b0;
        if (phase == 0) begin
            if (prog_low) begin lo_x = int'(w[8:0]); phase = 1; end
            else begin store = 1'b1; phase = 2; end
        end else if (phase == 1) begin
            if (prog_low) hi_y = int'(w[8:0]);
            else begin hi_y = lo_x; store = 1'b1; end
            phase = 2;
        end else store = 1'b1;
        if (store && model.size() < DEPTH) model.push_back(w);
    endtask

    task automatic pop_try(output bit popped);
        popped = 1'b0;
        @(negedge un_clk);
        if (empty_n) begin
            check(model.size() > 0, "R11 head valid with model empty", 32'(model.size()), 32'd1);
            if (model.size() > 0)
                check(q_out === model[0], "R11 order/data", 32'(q_out), 32'(model[0]));
            un_en = 1'b1;
            @(negedge un_clk);
            un_en = 1'b0;
            if (model.size() > 0) void'(model.pop_front());
            popped = 1'b1;
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge un_clk);
    endtask

    task automatic chk_flags(input string where);
        int c;
        settle();
        c = model.size();
        check(full_n === (c != DEPTH), {"R1 full_n ", where}, 32'(full_n), 32'(c != DEPTH));
        check(half_full === exp_half(c), {"R5 half_full ", where}, 32'(half_full), 32'(exp_half(c)));
        check(almost === exp_alm(c), {"R6 almost ", where}, 32'(almost), 32'(exp_alm(c)));
        check(empty_n === (c != 0), {"R4 empty_n ", where}, 32'(empty_n), 32'(c != 0));
    endtask

    task automatic fill_to(input int target);
        while (model.size() < target) ld_edge(DW'($urandom(seed_v)), 1'b0);
    endtask

    task automatic drain_all();
        bit p;
        while (model.size() > 0) begin
            if (($urandom(seed_v) % 3) == 0) @(negedge un_clk);
            pop_try(p);
        end
    endtask

    initial begin
        #1_500_000;
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        bit p;
        int n;
        int targets_a [9] = '{1, 10, 11, 255, 256, 491, 492, 511, 512};
        int targets_c [4] = '{5, 6, 506, 507};
        seed_v = 32'h5eed_1234;
        void'($urandom(seed_v));

        // ---- reset state R9
        rst_n = 1'b0;
        repeat (2) @(negedge un_clk);
        check(full_n === 1'b1, "R9 full_n in reset", 32'(full_n), 32'd1);
        check(empty_n === 1'b0, "R9 empty_n in reset", 32'(empty_n), 32'd0);
        reset_dut();
        @(negedge un_clk);
        check(half_full === 1'b0, "R9 half_full after reset", 32'(half_full), 32'd0);
        check(almost === 1'b1, "R9 almost after reset", 32'(almost), 32'd1);

        // ---- scenario A: programmed X=10 Y=20 (R7)
        ld_edge(18'h3_f00A, 1'b1);
        ld_edge(18'h2_a014, 1'b1);
        settle();
        check(empty_n === 1'b0, "R7 programming stores nothing", 32'(empty_n), 32'd0);
        check(lo_x == 10 && hi_y == 20, "R7 model offsets", 32'(lo_x), 32'd10);

        // fall-through latency R4
        ld_edge(18'h1_2345, 1'b0);
        n = 0;
        while (!empty_n && n < 8) begin @(negedge un_clk); n++; end
        check(n <= 4, "R4 first word latency (un edges)", 32'(n), 32'd4);
        check(q_out === 18'h1_2345, "R4 first word on output", 32'(q_out), 32'h12345);

        // output enable R10
        oe_n = 1'b1; #1;
        check(q_out === {DW{1'bz}}, "R10 outputs high-Z", 32'(q_out), 32'h0);
        oe_n = 1'b0; #1;
        check(q_out === 18'h1_2345, "R10 outputs driven again", 32'(q_out), 32'h12345);

        foreach (targets_a[i]) begin
            fill_to(targets_a[i]);
            chk_flags($sformatf("A count=%0d", targets_a[i]));
        end

        // write while full R2
        ld_edge(18'h3_ffff, 1'b0);
        chk_flags("R2 after load while full");
        drain_all();
        chk_flags("A drained");

        // unload while empty R3
        @(negedge un_clk); un_en = 1'b1;
        @(negedge un_clk); @(negedge un_clk); un_en = 1'b0;
        settle();
        check(empty_n === 1'b0, "R3 empty stays after unload", 32'(empty_n), 32'd0);
        ld_edge(18'h0_0777, 1'b0);
        settle();
        check(q_out === 18'h0_0777, "R3 next word delivered", 32'(q_out), 32'h777);
        drain_all();

        // ---- scenario B: no programming, defaults 64 (R8), random traffic (R11)
        reset_dut();
        ld_edge(18'h2_0001, 1'b0);
        check(phase == 2, "R8 first edge treated as data", 32'(phase), 32'd2);
        fill_to(64);
        chk_flags("B default count=64");
        fill_to(65);
        chk_flags("B default count=65");
        for (int k = 0; k < 800; k++) begin
            if (($urandom(seed_v) % 2) == 0 && model.size() < 400)
                ld_edge(DW'($urandom(seed_v)), 1'b0);
            else
                pop_try(p);
        end
        drain_all();
        chk_flags("B drained");

        // ---- scenario C: X=5, prog high on second edge -> Y=X, word stored (R8)
        reset_dut();
        ld_edge(18'h0_0005, 1'b1);
        ld_edge(18'h1_5a5a, 1'b0);
        check(hi_y == 5, "R8 model Y copies X", 32'(hi_y), 32'd5);
        settle();
        check(q_out === 18'h1_5a5a, "R8 second edge stores word", 32'(q_out), 32'h15a5a);
        foreach (targets_c[i]) begin
            fill_to(targets_c[i]);
            chk_flags($sformatf("C count=%0d", targets_c[i]));
        end
        drain_all();

        finish_run();
    end
endmodule